// File: doc/BRIEF.md
# Programmable clock output stop controller

This block sits between the clock dividers of a system clock generator and its output pins. It receives one undivided clock per output group (CPU, SDRAM, PCI, free-running PCI, AGP, 48 MHz and reference) and produces one gated clock and one output-enable for every pin. Each pin can be switched off by its own enable bit. Two active-low stop pins can halt whole groups. An asynchronous power-down pin halts everything, and a global bit releases every pin to high impedance.

A two-bit selection field chooses which groups the data-group stop pin halts. A mode strap is captured while reset is held. In mobile mode the pin that normally carries SDRAM clock 10 stops being driven and is read back as the PCI stop input. In desktop mode that pin stays a clock and PCI stop is inactive. Stop requests are synchronized into the domain of the clock they gate. A clock starts or stops only on its falling edge, so no shortened high pulse ever reaches a pin.

Top module: `clkstop_ctrl`

## Requirements
- R1: An inactive output is held at logic low and does not toggle. When it is active, its pin carries its group clock. Output index map: CPU 0-1, SDRAM 2-14 (SDRAM n at 2+n), PCI 15-20, free-running PCI 21, AGP 22-23, 48 MHz 24, reference 25.
- R2: `out_en[i]` = 1 enables pin i and 0 disables it. The change is taken at the next falling edge of the group clock, so it shows in the high phase that starts one rising edge after the write.
- R3: While the PCI stop input is low, all PCI clocks (15-20) stop. The free-running PCI clock (21) keeps running. CPU, 48 MHz and reference clocks are never stopped by a pin.
- R4: `dg_sel` decides what a low `dg_stop_n` halts: 01 halts SDRAM and AGP, 10 halts only AGP, 11 halts only SDRAM, and 00 halts nothing.
- R5: `mode_strap` is sampled on rising edges of the reference clock while `rst_n` is low: 1 selects desktop mode and 0 selects mobile mode. Changes to the strap after reset have no effect.
- R6: In mobile mode, pin 12 (SDRAM 10) has its output-enable low and its clock held low, and `sd10_pin_in` is the active-low PCI stop input. In desktop mode, `sd10_pin_in` is ignored.
- R7: While `hiz_all` = 1, every `oe_out` bit is 0. While it is 0, every bit is 1, except pin 12 in mobile mode.
- R8: A low `pd_n` clears every gated clock at once, without waiting for a clock edge.
- R9: A stop request is passed through two rising-edge flops of its group clock and is then applied at the following falling edge. A pin change made just after rising edge k shows in the high phase after rising edge k+3, and run state changes only while the group clock is low.
- R10: After `pd_n` or `rst_n` is released, no output resumes until its synchronizer has seen two rising edges of its own clock.
- R11: When an enable bit and a stop pin both act on a pin, it runs only if it is enabled and not stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Power-on reset, active low |
| pd_n | input | 1 | Asynchronous power-down, active low |
| ck_cpu | input | 1 | Undivided CPU group clock |
| ck_sdram | input | 1 | Undivided SDRAM group clock |
| ck_pci | input | 1 | Undivided PCI clock (stoppable and free-running groups) |
| ck_agp | input | 1 | Undivided AGP group clock |
| ck_48m | input | 1 | Undivided 48 MHz clock |
| ck_ref | input | 1 | Reference clock, also clocks the strap capture |
| mode_strap | input | 1 | Mode strap, 1 desktop, 0 mobile |
| dg_stop_n | input | 1 | Data-group stop pin, active low |
| sd10_pin_in | input | 1 | Level read back from pin 12, PCI stop in mobile mode |
| out_en | input | 26 | Per-pin enable bits |
| dg_sel | input | 2 | Selects which groups `dg_stop_n` halts |
| hiz_all | input | 1 | Global high-impedance request |
| clk_out | output | 26 | Gated clock per pin |
| oe_out | output | 26 | Output-enable per pin |

## Verification
The delicate collisions are two stop sources landing in the same cycle. In one case, the PCI stop on the strapped pin and the data-group stop are pulled low together in mobile mode. In the other, an enable bit is cleared on an SDRAM pin that the data-group stop is already halting. Power-down release is also made to coincide with held enables, to show the two-edge restart. A behavioural bench model keeps a short history of pins, enables and the reset and power-down state. Every cycle it predicts each pin in the high phase and requires all pins low in the low phase, so a stop that lands one cycle early or late, or a wrong priority between two sources, shows up as a mismatch on a named pin.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  localparam int NGRP    = 7;
  localparam int G_CPU   = 0;
  localparam int G_SDR   = 1;
  localparam int G_PCI   = 2;
  localparam int G_PCIF  = 3;
  localparam int G_AGP   = 4;
  localparam int G_F48   = 5;
  localparam int G_REF   = 6;

  localparam int DEF_NCPU = 2;
  localparam int DEF_NSDR = 13;
  localparam int DEF_NPCI = 6;
  localparam int DEF_NAGP = 2;

  typedef enum logic [1:0] {
    DG_NONE = 2'b00,
    DG_BOTH = 2'b01,
    DG_AGP  = 2'b10,
    DG_SDR  = 2'b11
  } dg_sel_e;

  // number of pins in a group
  function automatic int grp_width(int g, int nc, int ns, int np, int na);
    case (g)
      G_CPU:   return nc;
      G_SDR:   return ns;
      G_PCI:   return np;
      G_AGP:   return na;
      default: return 1;
    endcase
  endfunction

  // first pin index of a group
  function automatic int grp_offset(int g, int nc, int ns, int np, int na);
    int acc;
    acc = 0;
    for (int k = 0; k < NGRP; k++) begin
      if (k < g) acc += grp_width(k, nc, ns, np, na);
    end
    return acc;
  endfunction

  function automatic int total_pins(int nc, int ns, int np, int na);
    return grp_offset(NGRP, nc, ns, np, na);
  endfunction

  function automatic logic dg_hits_sdr(logic [1:0] sel);
    return (sel == DG_BOTH) || (sel == DG_SDR);
  endfunction

  function automatic logic dg_hits_agp(logic [1:0] sel);
    return (sel == DG_BOTH) || (sel == DG_AGP);
  endfunction

endpackage

// File: rtl/cs_mode_latch.sv
module cs_mode_latch (
  input  logic ck,
  input  logic rst_n,
  input  logic strap,
  output logic desktop
);
  // captured only while reset is held
  always_ff @(posedge ck) begin
    if (!rst_n) desktop <= strap;
  end
endmodule

// File: rtl/cs_stop_decode.sv
module cs_stop_decode
  import clkstop_pkg::*;
(
  input  logic            dg_stop_n,
  input  logic [1:0]      dg_sel,
  input  logic            sd10_pin_in,
  input  logic            desktop,
  output logic [NGRP-1:0] stop_req
);
  logic dg_low;
  logic pci_low;

  assign dg_low  = !dg_stop_n;
  assign pci_low = !desktop && !sd10_pin_in;

  always_comb begin
    stop_req         = '0;
    stop_req[G_SDR]  = dg_low && dg_hits_sdr(dg_sel);
    stop_req[G_AGP]  = dg_low && dg_hits_agp(dg_sel);
    stop_req[G_PCI]  = pci_low;
  end
endmodule

// File: rtl/cs_group_gate.sv
module cs_group_gate #(
  parameter int W = 1
) (
  input  logic         grp_clk,
  input  logic         arst_n,
  input  logic         stop_req,
  input  logic [W-1:0] en,
  output logic [W-1:0] gclk,
  output logic [W-1:0] run,
  output logic         ready
);
  logic s0;
  logic s1;

  // two-flop synchronizer; reset value means "held"
  always_ff @(posedge grp_clk or negedge arst_n) begin
    if (!arst_n) begin
      s0 <= 1'b0;
      s1 <= 1'b0;
    end else begin
      s0 <= !stop_req;
      s1 <= s0;
    end
  end

  assign ready = s1;

  // run state moves only on the falling edge
  always_ff @(negedge grp_clk or negedge arst_n) begin
    if (!arst_n) run <= '0;
    else         run <= en & {W{s1}};
  end

  assign gclk = {W{grp_clk}} & run;
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int N_CPU  = DEF_NCPU,
  parameter int N_SDR  = DEF_NSDR,
  parameter int N_PCI  = DEF_NPCI,
  parameter int N_AGP  = DEF_NAGP,
  parameter int SD_PIN = 10,
  localparam int NOUT  = total_pins(N_CPU, N_SDR, N_PCI, N_AGP)
) (
  input  logic            rst_n,
  input  logic            pd_n,
  input  logic            ck_cpu,
  input  logic            ck_sdram,
  input  logic            ck_pci,
  input  logic            ck_agp,
  input  logic            ck_48m,
  input  logic            ck_ref,
  input  logic            mode_strap,
  input  logic            dg_stop_n,
  input  logic            sd10_pin_in,
  input  logic [NOUT-1:0] out_en,
  input  logic [1:0]      dg_sel,
  input  logic            hiz_all,
  output logic [NOUT-1:0] clk_out,
  output logic [NOUT-1:0] oe_out
);
  localparam int SDR_OFF = grp_offset(G_SDR, N_CPU, N_SDR, N_PCI, N_AGP);
  localparam int SD10    = SDR_OFF + SD_PIN;

  logic            arst_n;
  logic            desktop_q;
  logic [NGRP-1:0] grp_clk;
  logic [NGRP-1:0] stop_req;
  logic [NGRP-1:0] sync_ok;
  logic [NOUT-1:0] run_all;
  logic [NOUT-1:0] gated_all;

  assign arst_n = rst_n & pd_n;

  always_comb begin
    grp_clk         = '0;
    grp_clk[G_CPU]  = ck_cpu;
    grp_clk[G_SDR]  = ck_sdram;
    grp_clk[G_PCI]  = ck_pci;
    grp_clk[G_PCIF] = ck_pci;
    grp_clk[G_AGP]  = ck_agp;
    grp_clk[G_F48]  = ck_48m;
    grp_clk[G_REF]  = ck_ref;
  end

  cs_mode_latch i_mode (
    .ck      (ck_ref),
    .rst_n   (rst_n),
    .strap   (mode_strap),
    .desktop (desktop_q)
  );

  cs_stop_decode i_dec (
    .dg_stop_n   (dg_stop_n),
    .dg_sel      (dg_sel),
    .sd10_pin_in (sd10_pin_in),
    .desktop     (desktop_q),
    .stop_req    (stop_req)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int W   = grp_width(g, N_CPU, N_SDR, N_PCI, N_AGP);
    localparam int OFF = grp_offset(g, N_CPU, N_SDR, N_PCI, N_AGP);
    cs_group_gate #(.W(W)) i_gate (
      .grp_clk  (grp_clk[g]),
      .arst_n   (arst_n),
      .stop_req (stop_req[g]),
      .en       (out_en[OFF +: W]),
      .gclk     (gated_all[OFF +: W]),
      .run      (run_all[OFF +: W]),
      .ready    (sync_ok[g])
    );
  end

  always_comb begin
    clk_out       = gated_all;
    clk_out[SD10] = gated_all[SD10] & desktop_q;
    oe_out        = {NOUT{!hiz_all}};
    oe_out[SD10]  = !hiz_all && desktop_q;
  end

endmodule

// File: rtl/cs_checker.sv
module cs_checker
  import clkstop_pkg::*;
#(
  parameter int N_CPU = DEF_NCPU,
  parameter int N_SDR = DEF_NSDR,
  parameter int N_PCI = DEF_NPCI,
  parameter int N_AGP = DEF_NAGP,
  parameter int SD10  = 12,
  localparam int NOUT = total_pins(N_CPU, N_SDR, N_PCI, N_AGP)
) (
  input logic            rst_n,
  input logic            pd_n,
  input logic [NGRP-1:0] grp_clk,
  input logic            en_ref,
  input logic            en_pcif,
  input logic [1:0]      dg_sel,
  input logic            hiz_all,
  input logic [NOUT-1:0] oe_out,
  input logic [NOUT-1:0] run_all,
  input logic [NGRP-1:0] stop_req,
  input logic [NGRP-1:0] sync_ok,
  input logic            desktop_q
);
  localparam int REF_I  = grp_offset(G_REF,  N_CPU, N_SDR, N_PCI, N_AGP);
  localparam int PCIF_I = grp_offset(G_PCIF, N_CPU, N_SDR, N_PCI, N_AGP);
  localparam int PCI_I  = grp_offset(G_PCI,  N_CPU, N_SDR, N_PCI, N_AGP);

  // R2: a cleared enable gives a cleared run state after the falling edge
  a_r2_disable_takes: assert property (@(negedge grp_clk[G_REF])
    disable iff (!rst_n || !pd_n) !en_ref |=> !run_all[REF_I]);

  // R3: free-running PCI is untouched by the PCI stop
  a_r3_pcif_free: assert property (@(negedge grp_clk[G_PCI])
    disable iff (!rst_n || !pd_n) (en_pcif && sync_ok[G_PCIF]) |=> run_all[PCIF_I]);

  // R3: groups without a stop pin never see a request
  a_r3_free_groups: assert property (@(posedge grp_clk[G_REF])
    disable iff (!rst_n)
    !stop_req[G_CPU] && !stop_req[G_PCIF] && !stop_req[G_F48] && !stop_req[G_REF]);

  // R3: a held PCI stop clears the PCI run state
  a_r3_pci_halt: assert property (@(negedge grp_clk[G_PCI])
    disable iff (!rst_n || !pd_n)
    ($past(stop_req[G_PCI]) && stop_req[G_PCI]) |-> ##2 !run_all[PCI_I]);

  // R4: reserved selection halts nothing
  a_r4_sel_none: assert property (@(posedge grp_clk[G_SDR])
    disable iff (!rst_n) (dg_sel == 2'b00) |-> (!stop_req[G_SDR] && !stop_req[G_AGP]));

  // R6: mobile mode releases pin 12
  a_r6_mobile_pin: assert property (@(posedge grp_clk[G_REF])
    disable iff (!rst_n) !desktop_q |-> !oe_out[SD10]);

  // R7: global high impedance
  a_r7_hiz: assert property (@(posedge grp_clk[G_REF])
    disable iff (!rst_n) hiz_all |-> (oe_out == '0));

  // R8: power-down clears every run state
  a_r8_pd_clear: assert property (@(posedge grp_clk[G_REF])
    disable iff (!rst_n) !pd_n |-> (run_all == '0));

  // R10: after power-down release the synchronizers are still empty
  a_r10_two_edges: assert property (@(posedge grp_clk[G_PCI])
    disable iff (!rst_n || !pd_n) $rose(pd_n) |=> (sync_ok == '0));

  // R9: run state changes only while the group clock is low
  for (genvar g = 0; g < NGRP; g++) begin : g_edge
    localparam int W   = grp_width(g, N_CPU, N_SDR, N_PCI, N_AGP);
    localparam int OFF = grp_offset(g, N_CPU, N_SDR, N_PCI, N_AGP);
    logic [W-1:0] slice;
    assign slice = run_all[OFF +: W];
    always @(slice) begin
      if (rst_n && pd_n) begin
        a_r9_low_phase: assert (!grp_clk[g]);
      end
    end
  end

endmodule

bind clkstop_ctrl cs_checker #(
  .N_CPU (N_CPU),
  .N_SDR (N_SDR),
  .N_PCI (N_PCI),
  .N_AGP (N_AGP),
  .SD10  (SD10)
) i_chk (
  .rst_n     (rst_n),
  .pd_n      (pd_n),
  .grp_clk   (grp_clk),
  .en_ref    (out_en[NOUT-1]),
  .en_pcif   (out_en[grp_offset(clkstop_pkg::G_PCIF, N_CPU, N_SDR, N_PCI, N_AGP)]),
  .dg_sel    (dg_sel),
  .hiz_all   (hiz_all),
  .oe_out    (oe_out),
  .run_all   (run_all),
  .stop_req  (stop_req),
  .sync_ok   (sync_ok),
  .desktop_q (desktop_q)
);

// File: tb/test_clkstop_ctrl.sv
module test_clkstop_ctrl;
  localparam int NOUT = 26;
  localparam int PIN12 = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic            rst_n, pd_n, mode_strap, dg_stop_n, sd10_pin_in, hiz_all;
  logic [NOUT-1:0] out_en;
  logic [1:0]      dg_sel;
  logic [NOUT-1:0] clk_out, oe_out;

  clkstop_ctrl i_clkstop_ctrl (
    .rst_n(rst_n), .pd_n(pd_n),
    .ck_cpu(clk), .ck_sdram(clk), .ck_pci(clk), .ck_agp(clk), .ck_48m(clk), .ck_ref(clk),
    .mode_strap(mode_strap), .dg_stop_n(dg_stop_n), .sd10_pin_in(sd10_pin_in),
    .out_en(out_en), .dg_sel(dg_sel), .hiz_all(hiz_all),
    .clk_out(clk_out), .oe_out(oe_out)
  );

  // next values, applied just after a rising edge
  logic            n_rst = 0, n_pd = 1, n_strap = 1, n_dg = 1, n_sd10 = 1, n_hiz = 0;
  logic [NOUT-1:0] n_en = '1;
  logic [1:0]      n_sel = 2'b01;

  int    n_chk = 0, n_fail = 0, cyc_cnt = 0;
  string cur = "R1";
  logic  exp_mode = 1'b1;

  // history, index 0 = current cycle
  logic            h_a  [4];
  logic [NOUT-1:0] h_en [4];
  logic [6:0]      h_go [4];

  // group of a pin: 0 cpu,1 sdram,2 pci,3 free pci,4 agp,5 48M,6 ref
  function automatic int group_of(int i);
    if (i < 2)   return 0;
    if (i < 15)  return 1;
    if (i < 21)  return 2;
    if (i == 21) return 3;
    if (i < 24)  return 4;
    if (i == 24) return 5;
    return 6;
  endfunction

  function automatic logic [6:0] go_of(logic dgn, logic [1:0] sel, logic sd10, logic mode);
    logic [6:0] v;
    v = 7'h7f;
    if (!dgn) begin
      if (sel == 2'b01) begin v[1] = 0; v[4] = 0; end
      else if (sel == 2'b10) v[4] = 0;
      else if (sel == 2'b11) v[1] = 0;
    end
    if (!mode && !sd10) v[2] = 0;
    return v;
  endfunction

  task automatic chk(string tag, logic [NOUT-1:0] act, logic [NOUT-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic cyc();
    logic [NOUT-1:0] e_clk, e_oe;
    logic alive;
    @(posedge clk);
    if (!rst_n) exp_mode = mode_strap;
    #1;
    rst_n = n_rst; pd_n = n_pd; mode_strap = n_strap; dg_stop_n = n_dg;
    sd10_pin_in = n_sd10; hiz_all = n_hiz; out_en = n_en; dg_sel = n_sel;
    for (int k = 3; k > 0; k--) begin
      h_a[k] = h_a[k-1]; h_en[k] = h_en[k-1]; h_go[k] = h_go[k-1];
    end
    h_a[0]  = n_rst & n_pd;
    h_en[0] = n_en;
    h_go[0] = go_of(n_dg, n_sel, n_sd10, exp_mode);
    #1;
    alive = h_a[0] & h_a[1] & h_a[2] & h_a[3];
    for (int i = 0; i < NOUT; i++) begin
      e_clk[i] = alive & h_en[1][i] & h_go[3][group_of(i)];
      e_oe[i]  = !n_hiz;
    end
    e_clk[PIN12] = e_clk[PIN12] & exp_mode;
    e_oe[PIN12]  = !n_hiz & exp_mode;
    chk(cur, clk_out, e_clk);
    chk(cur, oe_out, e_oe);
    #4;
    chk("R1", clk_out, '0);    // low phase: nothing high
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 50000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin h_a[k] = 0; h_en[k] = '0; h_go[k] = '0; end
    rst_n = 0; pd_n = 1; mode_strap = 1; dg_stop_n = 1; sd10_pin_in = 1;
    hiz_all = 0; out_en = '1; dg_sel = 2'b01;

    cur = "R10"; run(4);               // reset, desktop strap
    n_rst = 1; run(6);                 // two-edge restart after reset
    cur = "R11"; run(4);
    cur = "R2";  n_en = 26'h2aaaaaa; run(5);
    n_en = 26'h1555555; run(5);
    n_en = '1; run(4);
    cur = "R4";  n_dg = 0; n_sel = 2'b01; run(6);
    n_sel = 2'b10; run(6);
    n_sel = 2'b11; run(6);
    n_sel = 2'b00; run(6);
    n_dg = 1; n_sel = 2'b01; run(4);
    cur = "R6";  n_sd10 = 0; run(6);   // desktop: pin read-back ignored
    n_sd10 = 1; run(3);
    cur = "R11"; n_dg = 0; n_sel = 2'b11; n_en[5] = 0; n_en[24] = 0; run(6);
    n_dg = 1; run(5);
    n_en = '1; run(3);
    cur = "R9";  n_dg = 0; run(1);      // single-cycle stop pulse
    n_dg = 1; run(6);
    cur = "R7";  n_hiz = 1; run(4);
    n_hiz = 0; run(3);
    cur = "R8";  n_pd = 0; run(4);
    cur = "R10"; n_pd = 1; run(6);

    // mobile mode
    cur = "R5";  n_strap = 0; run(1);
    n_rst = 0; run(3);
    n_rst = 1; run(6);
    cur = "R6";  n_sd10 = 0; run(6);   // PCI stop from pin 12
    n_sd10 = 1; run(5);
    cur = "R3";  n_sd10 = 0; n_dg = 0; n_sel = 2'b01; run(6);
    n_sd10 = 1; n_dg = 1; run(5);
    cur = "R5";  n_strap = 1; run(6);   // strap ignored after reset
    chk("R5", {25'd0, oe_out[PIN12]}, '0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule